// File: doc/BRIEF.md
# Raster Line and Frame Timer with Vertical-Blank Interrupt

This block produces the raster timing skeleton of a video display engine. A dot counter steps once per clock across each scanline. A line counter steps at the end of each scanline. A frame counter steps each time the line counter returns to the top. When the raster reaches the first vertical-blank scanline, the block latches an interrupt flag. If the processor has enabled it, the block also issues a one-clock interrupt request.

The processor polls timing state through a byte-wide read port. One address reports the latched interrupt flag in its top bit. A second address reports vertical blank in bit 7 and horizontal blank in bit 6. The horizontal-blank window spans the end of one scanline and the start of the next. Every other address reads as zero. A one-clock frame-start pulse marks each wrap back to scanline 0, so that downstream logic can align to it.

Top module: `raster_timing`

## Requirements
- R1: A synchronous reset sets the dot, line and frame counters to zero and clears the interrupt flag and the enable bit. During reset, irq and frameStart are low, frameCount is 0, and address 0x4210 reads 0x00.
- R2: The dot counter steps 0, 1, …, 340 and then returns to 0, so one scanline lasts 341 clocks.
- R3: The line counter steps by one each time the dot counter returns to 0. When a step would bring it to 260, it returns to 0 instead and frameCount increments by one.
- R4: A read of address 0x4210 returns 0x80 from the clock on which the line counter becomes 225 until the clock on which it wraps to 0, and returns 0x00 at all other times.
- R5: In a read of address 0x4212, bit 7 is 1 exactly when the line counter is 225 or more.
- R6: In a read of address 0x4212, bit 6 is 1 exactly when the dot counter is at least 0x121 or at most 0x15. Bits 5 to 0 are 0.
- R7: irq is high for exactly one clock, the clock on which the line counter becomes 225. It is raised only if the enable bit held 1 before that clock edge.
- R8: A write with irqEnWrite high loads irqEnData into the enable bit. While the enable bit is 0, the vertical-blank entry raises no irq, but the flag at 0x4210 is still set.
- R9: frameStart is high for exactly one clock, the clock on which the line counter wraps from 259 to 0. It is not raised on leaving reset.
- R10: A read of any address other than 0x4210 and 0x4212 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| irqEnWrite | input | 1 | Strobe that loads the interrupt enable bit |
| irqEnData | input | 1 | Value loaded into the enable bit |
| rdAddr | input | 16 | Status read address |
| rdData | output | 8 | Status byte for rdAddr, combinational |
| irq | output | 1 | One-clock interrupt request on vertical-blank entry |
| frameStart | output | 1 | One-clock pulse when the raster wraps to line 0 |
| frameCount | output | 16 | Completed-frame counter |

## Verification
The assertions assume that reset is held for at least one clock before it is released. They also assume that rdAddr and the enable inputs change only between clock edges. Under those conditions, every counter and flag relation follows from the clock alone. The bench drives all inputs on the falling edge and samples outputs there as well. It draws read addresses at random from the two status addresses, a neighbouring unmapped address and arbitrary 16-bit values. Random enable writes fall early in each frame. Directed writes then fix the enable state before each vertical-blank entry, so that one frame takes the enabled path and the next takes the disabled path.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Timing events decoded by the control path for the datapath.
  typedef struct packed {
    logic lineWrap;     // last dot of a scanline
    logic vblankEnter;  // last dot of the line before vertical blank
    logic frameWrap;    // last dot of the last line of the frame
  } rasterStrobe_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int DOT_LAST    = 340,
  parameter int LINES       = 260,
  parameter int VBLANK_LINE = 225,
  parameter int DOT_W       = 9,
  parameter int LINE_W      = 9
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output rasterStrobe_t     strobe
);
  localparam logic [DOT_W-1:0]  DotEnd    = DOT_W'(DOT_LAST);
  localparam logic [LINE_W-1:0] PreVblank = LINE_W'(VBLANK_LINE - 1);
  localparam logic [LINE_W-1:0] LineEnd   = LINE_W'(LINES - 1);

  logic atLineEnd;

  always_comb begin
    atLineEnd          = (dot == DotEnd);
    strobe.lineWrap    = atLineEnd;
    strobe.vblankEnter = atLineEnd && (line == PreVblank);
    strobe.frameWrap   = atLineEnd && (line == LineEnd);
  end
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 9,
  parameter int FRAME_W    = 16,
  parameter int ADDR_W     = 16,
  parameter int VBLANK_LINE = 225,
  parameter int HBL_START  = 'h121,
  parameter int HBL_END    = 'h15,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h4210,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h4212
) (
  input  logic               clk,
  input  logic               rst,
  input  rasterStrobe_t      strobe,
  input  logic               irqEnWrite,
  input  logic               irqEnData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  output logic               irq,
  output logic               frameStart,
  output logic [FRAME_W-1:0] frameCount,
  output logic [DOT_W-1:0]   dot,
  output logic [LINE_W-1:0]  line,
  output logic               nmiFlag,
  output logic               nmiEnable
);
  localparam logic [DOT_W-1:0]  HblFirst = DOT_W'(HBL_START);
  localparam logic [DOT_W-1:0]  HblLast  = DOT_W'(HBL_END);
  localparam logic [LINE_W-1:0] VblFirst = LINE_W'(VBLANK_LINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot        <= '0;
      line       <= '0;
      frameCount <= '0;
      nmiFlag    <= 1'b0;
      nmiEnable  <= 1'b0;
      irq        <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      if (strobe.lineWrap) dot <= '0;
      else                 dot <= dot + 1'b1;

      if (strobe.frameWrap) begin
        line       <= '0;
        frameCount <= frameCount + 1'b1;
      end else if (strobe.lineWrap) begin
        line <= line + 1'b1;
      end

      if (strobe.vblankEnter)    nmiFlag <= 1'b1;
      else if (strobe.frameWrap) nmiFlag <= 1'b0;

      if (irqEnWrite) nmiEnable <= irqEnData;

      irq        <= strobe.vblankEnter & nmiEnable;
      frameStart <= strobe.frameWrap;
    end
  end

  logic inHblank;
  logic inVblank;

  always_comb begin
    inHblank = (dot >= HblFirst) || (dot <= HblLast);
    inVblank = (line >= VblFirst);
    rdData   = 8'h00;
    if (rdAddr == FLAG_ADDR)      rdData = {nmiFlag, 7'b0};
    else if (rdAddr == STAT_ADDR) rdData = {inVblank, inHblank, 6'b0};
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int DOT_LAST    = 340,
  parameter int LINES       = 260,
  parameter int VBLANK_LINE = 225,
  parameter int HBL_START   = 'h121,
  parameter int HBL_END     = 'h15,
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h4210,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h4212
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irqEnWrite,
  input  logic               irqEnData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  output logic               irq,
  output logic               frameStart,
  output logic [FRAME_W-1:0] frameCount
);
  localparam int DOT_W  = $clog2(DOT_LAST + 1);
  localparam int LINE_W = $clog2(LINES);

  raster_pkg::rasterStrobe_t strobe;
  logic [DOT_W-1:0]  dot;
  logic [LINE_W-1:0] line;
  logic              nmiFlag;
  logic              nmiEnable;

  raster_ctrl #(
    .DOT_LAST(DOT_LAST), .LINES(LINES), .VBLANK_LINE(VBLANK_LINE),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .dot(dot), .line(line), .strobe(strobe)
  );

  raster_datapath #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W),
    .VBLANK_LINE(VBLANK_LINE), .HBL_START(HBL_START), .HBL_END(HBL_END),
    .FLAG_ADDR(FLAG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .irqEnWrite(irqEnWrite), .irqEnData(irqEnData),
    .rdAddr(rdAddr), .rdData(rdData),
    .irq(irq), .frameStart(frameStart), .frameCount(frameCount),
    .dot(dot), .line(line), .nmiFlag(nmiFlag), .nmiEnable(nmiEnable)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int DOT_LAST    = 340,
  parameter int LINES       = 260,
  parameter int VBLANK_LINE = 225,
  parameter int DOT_W       = 9,
  parameter int LINE_W      = 9,
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h4212
) (
  input logic               clk,
  input logic               rst,
  input logic [DOT_W-1:0]   dot,
  input logic [LINE_W-1:0]  line,
  input logic               nmiFlag,
  input logic               nmiEnable,
  input logic               irq,
  input logic               frameStart,
  input logic [FRAME_W-1:0] frameCount,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [7:0]         rdData
);
  p_dot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (dot == DOT_W'(DOT_LAST)) |=> (dot == '0));

  p_dot_step_r2: assert property (@(posedge clk) disable iff (rst)
    (dot != DOT_W'(DOT_LAST)) |=> (dot == $past(dot) + 1'b1));

  p_line_range_r3: assert property (@(posedge clk) disable iff (rst)
    line <= LINE_W'(LINES - 1));

  p_frame_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (dot == DOT_W'(DOT_LAST) && line == LINE_W'(LINES - 1))
      |=> (frameCount == $past(frameCount) + 1'b1) && (line == '0));

  p_flag_window_r4: assert property (@(posedge clk) disable iff (rst)
    nmiFlag == (line >= LINE_W'(VBLANK_LINE)));

  p_stat_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == STAT_ADDR) |-> (rdData[5:0] == 6'b0));

  p_irq_entry_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($rose(nmiFlag) && $past(nmiEnable)));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(nmiFlag) && $past(nmiEnable)) |-> irq);

  p_frame_start_r9: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (line == '0 && dot == '0 && !nmiFlag));
endmodule

bind raster_timing raster_timing_chk #(
  .DOT_LAST(DOT_LAST), .LINES(LINES), .VBLANK_LINE(VBLANK_LINE),
  .DOT_W(DOT_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .dot(dot), .line(line), .nmiFlag(nmiFlag),
  .nmiEnable(nmiEnable), .irq(irq), .frameStart(frameStart),
  .frameCount(frameCount), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/test_raster_timing.sv
`timescale 1ns/1ps
module test_raster_timing;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irqEnWrite = 1'b0;
  logic        irqEnData = 1'b0;
  logic [15:0] rdAddr = 16'h4210;
  logic [7:0]  rdData;
  logic        irq;
  logic        frameStart;
  logic [15:0] frameCount;

  always #5 clk = ~clk;

  raster_timing i_raster_timing (
    .clk(clk), .rst(rst), .irqEnWrite(irqEnWrite), .irqEnData(irqEnData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
    .frameStart(frameStart), .frameCount(frameCount)
  );

  int nChecks = 0;
  int nFail = 0;
  int irqSeen = 0;
  int fsSeen = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference model built from the requirements
  int mDot = 0, mLine = 0, mFrame = 0;
  bit mEn = 0, expIrq = 0, expFs = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      mDot <= 0; mLine <= 0; mFrame <= 0; mEn <= 0; expIrq <= 0; expFs <= 0;
    end else begin
      if (mDot == 340) begin
        mDot <= 0;
        if (mLine == 259) begin
          mLine  <= 0;
          mFrame <= (mFrame + 1) % 65536;
        end else begin
          mLine <= mLine + 1;
        end
      end else begin
        mDot <= mDot + 1;
      end
      expIrq <= (mDot == 340) && (mLine == 224) && mEn;
      expFs  <= (mDot == 340) && (mLine == 259);
      if (irqEnWrite) mEn <= irqEnData;
    end
  end

  function automatic int expRead(input logic [15:0] a, input int d, input int l);
    if (a == 16'h4210) return (l >= 225) ? 'h80 : 0;
    if (a == 16'h4212) return ((l >= 225) ? 'h80 : 0) | ((d >= 'h121 || d <= 'h15) ? 'h40 : 0);
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h (line %0d dot %0d)", req, act, exp, mLine, mDot);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 frameStart", int'(frameStart), 0);
    check("R1 frameCount", int'(frameCount), 0);
    check("R1 flag read", int'(rdData), 0);
    rst = 1'b0;
    for (int cyc = 0; cyc < 2 * 88660 + 60; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        if (rdAddr == 16'h4210)      check("R4", int'(rdData), expRead(rdAddr, mDot, mLine));
        else if (rdAddr == 16'h4212) check("R2 R5 R6", int'(rdData), expRead(rdAddr, mDot, mLine));
        else                         check("R10", int'(rdData), 0);
        check(mEn ? "R7 irq" : "R8 irq", int'(irq), int'(expIrq));
        check("R9 frameStart", int'(frameStart), int'(expFs));
        check("R3 frameCount", int'(frameCount), mFrame);
        if (irq) irqSeen++;
        if (frameStart) fsSeen++;
      end
      // next stimulus
      case ($urandom % 4)
        0: rdAddr = 16'h4210;
        1: rdAddr = 16'h4212;
        2: rdAddr = 16'h4211;
        default: rdAddr = 16'($urandom);
      endcase
      irqEnWrite = 1'b0;
      if (mLine < 200 && ($urandom % 500) == 0) begin
        irqEnWrite = 1'b1;
        irqEnData  = 1'($urandom);
      end
      if (mLine == 210 && mDot == 0) begin
        irqEnWrite = 1'b1;
        irqEnData  = (mFrame == 0);  // enabled in frame 0, disabled in frame 1
      end
    end
    // R7/R8: exactly one request over two frames (enabled frame only)
    check("R7 R8 irq count", irqSeen, 1);
    check("R9 frameStart count", fsSeen, 2);
    done = 1'b1;
    finishRun();
  end

  initial begin
    wait (cycles >= 195000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual %0d expected <195000 cycles", cycles);
      finishRun();
    end
  end
endmodule